// File: doc/BRIEF.md
# Predictive Glitch-Free PWM Update Sequencer

This block feeds a stream of pulse widths into a PWM whose compare register has no shadow buffer. A raw write to such a register can cut or stretch the pulse in progress. The sequencer decides, one period at a time, which PWM event the next compare write is tied to: the terminal count (TC) or the output rising edge (RE). It makes that choice from the upcoming width, a threshold `thr_i` and a maximum width `maxw_i`. When a write would shrink the pulse in flight, it first writes the threshold and writes the final value later, or it holds the write back for a computed number of clocks.

The PWM reports its events on `tc_i` and `re_i`, which are one-cycle pulses. New widths arrive on a ready/valid port. `w_ready_o` is high exactly in a cycle where an event consumes a width. The sequencer drives `cmp_we_o` and `cmp_o` into the PWM compare register, and `src_re_o` into its event-source select.

The controller has three states:

- `TC_SRC`: the next update is tied to the terminal count.
- `RE_SRC`: the next update is tied to the rising edge.
- `SUB_SRC`: the width is at maximum, so no rising edge occurs, and the terminal count stands in for it.

Each event classifies the incoming width into one of three classes:

- LOW: the width is at or below `thr_i`.
- MID: the width is above `thr_i` and below `maxw_i`.
- MAX: the width is at or above `maxw_i`.

Together with the current state, this gives nine moves:

| From \ width class | LOW | MID | MAX |
|---|---|---|---|
| `TC_SRC` | stay-low | rise-to-edge | forbidden-jump |
| `RE_SRC` | edge-drop | edge-hold | edge-to-full |
| `SUB_SRC` | full-drop | full-to-edge | full-hold |

Top module: `gfp_sequencer`

## Requirements
- R1: After reset the state is `TC_SRC` and the last written width is 0. `cmp_we_o`, `cmp_o`, `src_re_o`, `err_o` and `underrun_o` are all 0.
- R2: In `TC_SRC` a `tc_i` pulse consumes one width and writes it, visible on `cmp_we_o`/`cmp_o` one clock after the event edge. A LOW width keeps `TC_SRC` (stay-low). A MID width moves to `RE_SRC` (rise-to-edge). `src_re_o` is 1 exactly while the state is `RE_SRC` and 0 otherwise.
- R3: In `TC_SRC` a MAX width (forbidden-jump) is consumed and dropped. `err_o` pulses for one clock, nothing is written and the state stays `TC_SRC`.
- R4: In `RE_SRC` a MID width that is not smaller than the last written width is written one clock after the `re_i` edge (edge-hold).
- R5: When a MID width W1 replaces a larger width W0 in `RE_SRC` or `SUB_SRC`, let d = W0 − W1 − `irq_cyc_i`. If d > 0 the write appears d clocks later than an immediate write. Otherwise the write is immediate.
- R6: In `RE_SRC` a MAX width writes `maxw_i` at once and moves to `SUB_SRC` (edge-to-full). `src_re_o` returns to 0.
- R7: In `SUB_SRC` a MAX width is consumed with no compare write, and the state stays `SUB_SRC` (full-hold).
- R8: On full-to-edge the state becomes `RE_SRC`, and the first `re_i` pulse after it is ignored: it consumes nothing and writes nothing.
- R9: On edge-drop or full-drop the sequencer writes `thr_i` at once and moves to `TC_SRC`. At the next `tc_i` it writes the LOW width it consumed earlier, without consuming a new one.
- R10: An event that does not match the current state is ignored, and so is any event while a delayed write is pending. No width is consumed and nothing is written. The events that do not match are `re_i` in `TC_SRC` or `SUB_SRC`, and `tc_i` in `RE_SRC`.
- R11: If an event would consume a width while `w_valid_i` is 0, `underrun_o` pulses for one clock. Nothing is written and the state is kept.
- R12: `w_ready_o` is high only in a cycle whose event consumes a width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_i | input | W | Threshold between terminal-count and rising-edge scheduling |
| maxw_i | input | W | Maximum width, at which the output never falls |
| irq_cyc_i | input | W | Update latency in clocks, subtracted from the shrink wait |
| w_valid_i | input | 1 | Next width is valid |
| w_data_i | input | W | Next width |
| w_ready_o | output | 1 | Width consumed this cycle |
| tc_i | input | 1 | Terminal-count event pulse from the PWM |
| re_i | input | 1 | Output rising-edge event pulse from the PWM |
| cmp_we_o | output | 1 | Compare register write strobe |
| cmp_o | output | W | Compare register write value |
| src_re_o | output | 1 | Event source select: 1 = rising edge, 0 = terminal count |
| err_o | output | 1 | One-clock pulse on a forbidden jump to maximum width |
| underrun_o | output | 1 | One-clock pulse when a width was due but not valid |

## Verification
The bench counts the exact clocks of the shrink waits after edge-hold and full-to-edge. An off-by-one counter, or a subtraction that drops the latency term, shows up as a strobe one cycle early or late. Two near-equal widths must give an immediate write: a design that compares without the latency would stall that write.

The bench checks the threshold write of the two-step drop and that the following terminal count writes the stored width without asserting ready. A design that reads a fresh width there loses a sample.

It also sends the spurious edge after full-to-edge, a forbidden jump, an underrun and events from the wrong source. A design that mishandles these would consume widths or write the compare register where it must stay quiet.

// File: rtl/gfp_pkg.sv
package gfp_pkg;
    typedef enum logic [1:0] {
        TC_SRC  = 2'd0,
        RE_SRC  = 2'd1,
        SUB_SRC = 2'd2
    } sched_e;

    typedef enum logic [1:0] {
        CL_LOW = 2'd0,
        CL_MID = 2'd1,
        CL_MAX = 2'd2
    } wclass_e;
endpackage

// File: rtl/gfp_width_class.sv
module gfp_width_class
    import gfp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] w_i,
    input  logic [W-1:0] thr_i,
    input  logic [W-1:0] maxw_i,
    output wclass_e      cls_o
);
    always_comb begin
        if (w_i >= maxw_i)     cls_o = CL_MAX;
        else if (w_i > thr_i)  cls_o = CL_MID;
        else                   cls_o = CL_LOW;
    end
endmodule

// File: rtl/gfp_wait_calc.sv
module gfp_wait_calc #(
    parameter int W = 8
) (
    input  logic [W-1:0] w0_i,
    input  logic [W-1:0] w1_i,
    input  logic [W-1:0] irq_i,
    output logic         need_o,
    output logic [W-1:0] dly_o
);
    localparam int WX = W + 1;
    logic [WX-1:0] sum;
    logic [WX-1:0] diff;

    always_comb begin
        sum    = {1'b0, w1_i} + {1'b0, irq_i};
        need_o = ({1'b0, w0_i} > sum);
        diff   = {1'b0, w0_i} - sum;
        dly_o  = diff[W-1:0];
    end
endmodule

// File: rtl/gfp_wait_timer.sv
module gfp_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dly_i,
    input  logic [W-1:0] val_i,
    output logic         busy_o,
    output logic         fire_o,
    output logic [W-1:0] val_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] val_q;
    logic         busy_q;

    assign busy_o = busy_q;
    assign val_o  = val_q;
    assign fire_o = busy_q && (cnt_q == W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            val_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= dly_i;
            val_q  <= val_i;
            busy_q <= 1'b1;
        end else if (fire_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - W'(1);
        end
    end

    // R5: the countdown steps by exactly one each clock while armed
    p_wait_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q > W'(1) && !start_i) |=> (busy_q && (cnt_q + W'(1)) == $past(cnt_q)));
    // R5: the timer disarms after firing
    p_wait_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/gfp_sequencer.sv
module gfp_sequencer
    import gfp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] thr_i,
    input  logic [W-1:0] maxw_i,
    input  logic [W-1:0] irq_cyc_i,
    input  logic         w_valid_i,
    input  logic [W-1:0] w_data_i,
    output logic         w_ready_o,
    input  logic         tc_i,
    input  logic         re_i,
    output logic         cmp_we_o,
    output logic [W-1:0] cmp_o,
    output logic         src_re_o,
    output logic         err_o,
    output logic         underrun_o
);
    sched_e       state_q, state_d;
    logic         pend_q, pend_d;
    logic [W-1:0] pendv_q, pendv_d;
    logic         skip_q, skip_d;
    logic [W-1:0] w0_q, w0_d;

    wclass_e      cls;
    logic         need_wait;
    logic [W-1:0] dly;
    logic         busy, fire;
    logic [W-1:0] fire_val;

    logic         take, we_now, start_w, err_d, und_d;
    logic [W-1:0] we_val;

    gfp_width_class #(.W(W)) u_cls (
        .w_i(w_data_i), .thr_i(thr_i), .maxw_i(maxw_i), .cls_o(cls)
    );

    gfp_wait_calc #(.W(W)) u_calc (
        .w0_i(w0_q), .w1_i(w_data_i), .irq_i(irq_cyc_i),
        .need_o(need_wait), .dly_o(dly)
    );

    gfp_wait_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .dly_i(dly),
        .val_i(w_data_i), .busy_o(busy), .fire_o(fire), .val_o(fire_val)
    );

    assign w_ready_o = take;

    // next-state and action decode
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        pendv_d = pendv_q;
        skip_d  = skip_q;
        w0_d    = w0_q;
        take    = 1'b0;
        we_now  = 1'b0;
        we_val  = w_data_i;
        start_w = 1'b0;
        err_d   = 1'b0;
        und_d   = 1'b0;

        if (!busy) begin
            unique case (state_q)
                TC_SRC: begin
                    if (tc_i) begin
                        if (pend_q) begin
                            we_now = 1'b1;
                            we_val = pendv_q;
                            w0_d   = pendv_q;
                            pend_d = 1'b0;
                        end else begin
                            take = 1'b1;
                        end
                    end
                end
                RE_SRC: begin
                    if (re_i) begin
                        if (skip_q) skip_d = 1'b0;
                        else        take   = 1'b1;
                    end
                end
                SUB_SRC: begin
                    if (tc_i) take = 1'b1;
                end
                default: ;
            endcase
        end

        if (take && !w_valid_i) begin
            und_d = 1'b1;
        end else if (take) begin
            unique case (state_q)
                TC_SRC: begin
                    if (cls == CL_MAX) begin
                        err_d = 1'b1;
                    end else begin
                        we_now = 1'b1;
                        w0_d   = w_data_i;
                        if (cls == CL_MID) state_d = RE_SRC;
                    end
                end
                RE_SRC, SUB_SRC: begin
                    if (cls == CL_LOW) begin
                        we_now  = 1'b1;
                        we_val  = thr_i;
                        pend_d  = 1'b1;
                        pendv_d = w_data_i;
                        w0_d    = w_data_i;
                        state_d = TC_SRC;
                    end else if (cls == CL_MID) begin
                        w0_d    = w_data_i;
                        state_d = RE_SRC;
                        if (state_q == SUB_SRC) skip_d = 1'b1;
                        if (need_wait) start_w = 1'b1;
                        else           we_now  = 1'b1;
                    end else begin
                        w0_d    = maxw_i;
                        state_d = SUB_SRC;
                        if (state_q == RE_SRC) begin
                            we_now = 1'b1;
                            we_val = maxw_i;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TC_SRC;
            pend_q  <= 1'b0;
            pendv_q <= '0;
            skip_q  <= 1'b0;
            w0_q    <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            pendv_q <= pendv_d;
            skip_q  <= skip_d;
            w0_q    <= w0_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_we_o   <= 1'b0;
            cmp_o      <= '0;
            src_re_o   <= 1'b0;
            err_o      <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            cmp_we_o   <= we_now | fire;
            if (we_now)    cmp_o <= we_val;
            else if (fire) cmp_o <= fire_val;
            src_re_o   <= (state_d == RE_SRC);
            err_o      <= err_d;
            underrun_o <= und_d;
        end
    end

    // R3: a forbidden jump never produces a compare write
    p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !cmp_we_o);
    // R11: an underrun never produces a compare write
    p_und_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> !cmp_we_o);
    // R12: consumption only happens on an event
    p_ready_evt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        w_ready_o |-> (tc_i || re_i));
    // R7: a maximum width held in SUB_SRC writes nothing
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUB_SRC && tc_i && !busy && w_valid_i && cls == CL_MAX) |=> !cmp_we_o);
    // R8: the edge right after full-to-edge consumes nothing
    p_skip_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RE_SRC && skip_q && re_i) |-> !w_ready_o);
    // R10: no width is taken while a delayed write is armed
    p_busy_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !w_ready_o);
endmodule

// File: tb/sim_gfp_sequencer.sv
module sim_gfp_sequencer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] thr_i = 8'd100;
    logic [W-1:0] maxw_i = 8'd255;
    logic [W-1:0] irq_cyc_i = 8'd5;
    logic         w_valid_i = 1'b0;
    logic [W-1:0] w_data_i = '0;
    logic         w_ready_o;
    logic         tc_i = 1'b0;
    logic         re_i = 1'b0;
    logic         cmp_we_o;
    logic [W-1:0] cmp_o;
    logic         src_re_o;
    logic         err_o;
    logic         underrun_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gfp_sequencer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_i(thr_i), .maxw_i(maxw_i),
        .irq_cyc_i(irq_cyc_i), .w_valid_i(w_valid_i), .w_data_i(w_data_i),
        .w_ready_o(w_ready_o), .tc_i(tc_i), .re_i(re_i),
        .cmp_we_o(cmp_we_o), .cmp_o(cmp_o), .src_re_o(src_re_o),
        .err_o(err_o), .underrun_o(underrun_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one event pulse; returns ready as seen before the edge
    task automatic evt(bit use_tc, bit vld, logic [W-1:0] w, output logic rdy);
        @(negedge clk);
        tc_i = use_tc; re_i = !use_tc; w_valid_i = vld; w_data_i = w;
        #1 rdy = w_ready_o;
        @(posedge clk);
        #1;
        tc_i = 1'b0; re_i = 1'b0; w_valid_i = 1'b0;
    endtask

    task automatic expect_write(string req, logic [W-1:0] v);
        chk({req, " we"}, int'(cmp_we_o), 1);
        chk({req, " val"}, int'(cmp_o), int'(v));
    endtask

    // after an event already sampled at e+1, the strobe must appear after edge e+n
    task automatic expect_delayed(string req, int n, logic [W-1:0] v);
        int early = 0;
        if (cmp_we_o) early++;
        for (int i = 1; i < n; i++) begin
            @(posedge clk); #1;
            if (cmp_we_o) early++;
        end
        chk({req, " early strobes"}, early, 0);
        @(posedge clk); #1;
        expect_write(req, v);
    endtask

    task automatic t_reset;
        chk("R1 we", int'(cmp_we_o), 0);
        chk("R1 cmp", int'(cmp_o), 0);
        chk("R1 src", int'(src_re_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 und", int'(underrun_o), 0);
    endtask

    task automatic t_low_and_rise;
        logic r;
        evt(1, 1, 8'd50, r);
        chk("R12 ready", int'(r), 1);
        expect_write("R2 stay-low", 8'd50);
        chk("R2 src", int'(src_re_o), 0);
        evt(0, 1, 8'd77, r);               // R10 edge in TC_SRC
        chk("R10 ready", int'(r), 0);
        chk("R10 we", int'(cmp_we_o), 0);
        evt(1, 1, 8'd200, r);
        expect_write("R2 rise-to-edge", 8'd200);
        chk("R2 src", int'(src_re_o), 1);
        evt(1, 1, 8'd90, r);               // R10 terminal count in RE_SRC
        chk("R10 ready tc", int'(r), 0);
        chk("R10 we tc", int'(cmp_we_o), 0);
    endtask

    task automatic t_edge_hold;
        logic r;
        evt(0, 1, 8'd220, r);
        expect_write("R4 grow", 8'd220);
        evt(0, 1, 8'd150, r);              // 220-150-5 = 65
        evt(0, 1, 8'd99, r);               // R10 edge during wait
        chk("R10 busy ready", int'(r), 0);
        expect_delayed("R5 shrink wait", 64, 8'd150);
        evt(0, 1, 8'd147, r);              // 3 <= 5: immediate
        expect_write("R5 short shrink", 8'd147);
        chk("R5 src", int'(src_re_o), 1);
    endtask

    task automatic t_full_paths;
        logic r;
        evt(0, 1, 8'd255, r);
        expect_write("R6 edge-to-full", 8'd255);
        chk("R6 src", int'(src_re_o), 0);
        evt(1, 1, 8'd255, r);
        chk("R7 ready", int'(r), 1);
        chk("R7 we", int'(cmp_we_o), 0);
        evt(1, 1, 8'd180, r);              // 255-180-5 = 70
        chk("R8 src", int'(src_re_o), 1);
        expect_delayed("R5 full-to-edge wait", 70, 8'd180);
        evt(0, 1, 8'd66, r);               // spurious edge
        chk("R8 ready", int'(r), 0);
        chk("R8 we", int'(cmp_we_o), 0);
        evt(0, 1, 8'd170, r);              // 180-170-5 = 5
        chk("R8 next edge ready", int'(r), 1);
        expect_delayed("R5 wait5", 5, 8'd170);
    endtask

    task automatic t_drop;
        logic r;
        evt(0, 1, 8'd40, r);
        expect_write("R9 edge-drop thr", 8'd100);
        chk("R9 src", int'(src_re_o), 0);
        evt(1, 0, 8'd0, r);
        chk("R9 no consume", int'(r), 0);
        expect_write("R9 final", 8'd40);
        chk("R9 no underrun", int'(underrun_o), 0);
    endtask

    task automatic t_underrun_and_err;
        logic r;
        evt(1, 0, 8'd0, r);
        chk("R11 und", int'(underrun_o), 1);
        chk("R11 we", int'(cmp_we_o), 0);
        evt(1, 1, 8'd255, r);
        chk("R3 ready", int'(r), 1);
        chk("R3 err", int'(err_o), 1);
        chk("R3 we", int'(cmp_we_o), 0);
        chk("R3 src", int'(src_re_o), 0);
        evt(1, 1, 8'd30, r);
        expect_write("R3 still TC", 8'd30);
        chk("R3 err clear", int'(err_o), 0);
    endtask

    task automatic t_full_drop;
        logic r;
        evt(1, 1, 8'd200, r);
        evt(0, 1, 8'd255, r);
        evt(1, 1, 8'd60, r);
        expect_write("R9 full-drop thr", 8'd100);
        evt(1, 1, 8'd11, r);
        chk("R9 full-drop ready", int'(r), 0);
        expect_write("R9 full-drop final", 8'd60);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_low_and_rise();
        t_edge_hold();
        t_full_paths();
        t_drop();
        t_underrun_and_err();
        t_full_drop();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule